// File: doc/BRIEF.md
# GPIO Register Bank with Streaming Control

This block gives a bus master word-level control over 32 general-purpose I/O pads through a Wishbone-style slave that occupies a 16-byte window. One word holds the set-up for an automatic bit-streaming engine. The other three words hold the sampled pad levels, the pad output values and the per-pad drive enables.

The streaming engine lives outside the block. The bank sends it the decoded control fields. When the engine finishes an input capture it pulses a clear line, and that pulse drops the input-stream enable bit. When output streaming is switched on, the pad picked by the output pin field takes its value and its drive enable from the engine instead of from the output registers. Every other pad keeps following the registers.

A bus master writes the output and drive-enable words to drive pads directly. It reads the input word to see the pads. It writes the control word to start a stream.

Top module: `gpio_regbank`

## Requirements
- R1: After a synchronous reset, every register reads zero, all control outputs are zero, `wb_ack_o` is low, and `pad_out_o` and `pad_oe_o` are all zero.
- R2: When `wb_cyc_i` and `wb_stb_i` are both high and `wb_ack_o` is low at a clock edge, `wb_ack_o` is high for exactly the next cycle. It is never high in two consecutive cycles, and `wb_dat_o` is zero whenever `wb_ack_o` is low.
- R3: The word is chosen by byte address bits [3:2]: 0 selects control, 1 selects input, 2 selects output and 3 selects output enable. Read data appears on `wb_dat_o` during the acknowledge cycle.
- R4: A write updates only the bytes whose `wb_sel_i` bit is set. Bit n of the select covers data bits [8n+7:8n].
- R5: The control word layout is: bit 0 input-stream enable, [5:1] input pin, bit 6 output-stream enable, [11:7] output pin, bit 12 loop enable, [22:13] output length, bit 23 length-limit enable. Bits [31:24] always read zero. Each field is presented on its own output port.
- R6: A high `in_done_i` at a clock edge clears control bit 0. This clear wins over a software write that sets the bit at the same edge.
- R7: The input word returns the value of `pad_in_i` captured at the clock edge before the read request edge. Writes to the input word are acknowledged and change nothing.
- R8: Apart from a pad under stream override, bit n of `pad_out_o` and `pad_oe_o` equals bit n of the output word and the output-enable word.
- R9: While the output-stream enable is set, the pad numbered by the output pin field drives `str_out_i` and `str_oe_i` combinationally, and no other pad is affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_cyc_i | input | 1 | Bus cycle valid |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | Write when high, read when low |
| wb_adr_i | input | 4 | Byte address within the window |
| wb_sel_i | input | 4 | Byte selects |
| wb_dat_i | input | 32 | Write data |
| wb_dat_o | output | 32 | Read data, valid with acknowledge |
| wb_ack_o | output | 1 | Acknowledge |
| in_done_i | input | 1 | Clear pulse for the input-stream enable |
| str_out_i | input | 1 | Streamed output bit from the engine |
| str_oe_i | input | 1 | Streamed drive enable from the engine |
| cfg_in_en_o | output | 1 | Input-stream enable |
| cfg_in_pin_o | output | 5 | Input streaming pad number |
| cfg_out_en_o | output | 1 | Output-stream enable |
| cfg_out_pin_o | output | 5 | Output streaming pad number |
| cfg_loop_o | output | 1 | Repeat the output stream |
| cfg_len_o | output | 10 | Output stream length |
| cfg_lim_o | output | 1 | Apply the length limit |
| pad_in_i | input | 32 | Pad input levels |
| pad_out_o | output | 32 | Pad output values |
| pad_oe_o | output | 32 | Pad drive enables |

## Verification
A wrong bit in the output or enable registers shows on the pad buses in the same cycle, so a reference comparison made every cycle catches it within one clock of the write that caused it. A corrupt control register shows on the field ports at once. It also moves the stream override to the wrong pad, which the pad buses show in the cycle it happens. A lost or misplaced hardware clear shows on the input-enable output one cycle after the pulse. Address-decode or byte-lane faults stay hidden until a read-back, and they appear during that read's acknowledge cycle.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int NPIN    = 32;
    localparam int DW      = 32;
    localparam int NBYTE   = DW / 8;
    localparam int PIN_W   = $clog2(NPIN);
    localparam int LEN_W   = 10;
    localparam int ADR_W   = 4;
    localparam int CTRL_W  = 4 + 2 * PIN_W + LEN_W;

    typedef enum logic [1:0] {
        SLOT_CTRL = 2'd0,
        SLOT_IN   = 2'd1,
        SLOT_OUT  = 2'd2,
        SLOT_OE   = 2'd3
    } slot_e;

    // Field order from MSB to LSB places ien at bit 0 and lim at bit 23.
    typedef struct packed {
        logic             lim;
        logic [LEN_W-1:0] len;
        logic             loop;
        logic [PIN_W-1:0] opin;
        logic             oen;
        logic [PIN_W-1:0] ipin;
        logic             ien;
    } ctrl_t;

    typedef struct packed {
        logic             wr;
        logic             rd;
        slot_e            slot;
        logic [NBYTE-1:0] sel;
        logic [DW-1:0]    wdata;
    } bus_op_t;

    function automatic logic [DW-1:0] byte_merge(
        input logic [DW-1:0]    cur,
        input logic [DW-1:0]    wdat,
        input logic [NBYTE-1:0] sel
    );
        logic [DW-1:0] r;
        r = cur;
        for (int b = 0; b < NBYTE; b++) begin
            if (sel[b]) r[b*8 +: 8] = wdat[b*8 +: 8];
        end
        return r;
    endfunction

    function automatic logic [DW-1:0] ctrl_to_word(input ctrl_t c);
        logic [DW-1:0] w;
        w = '0;
        w[CTRL_W-1:0] = c;
        return w;
    endfunction

endpackage

// File: rtl/gpio_bus_port.sv
module gpio_bus_port
    import gpio_bank_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cyc,
    input  logic             stb,
    input  logic             we,
    input  logic [ADR_W-1:0] adr,
    input  logic [NBYTE-1:0] sel,
    input  logic [DW-1:0]    wdat,
    input  logic [DW-1:0]    rd_word,
    output bus_op_t          op,
    output logic [DW-1:0]    dat_o,
    output logic             ack_o
);

    logic          ack_q;
    logic [DW-1:0] dat_q;
    logic          req;
    logic          unused_lo;

    assign unused_lo = ^adr[1:0];
    assign req       = cyc && stb && !ack_q;

    always_comb begin
        op       = '0;
        op.wr    = req && we;
        op.rd    = req && !we;
        op.slot  = slot_e'(adr[3:2]);
        op.sel   = sel;
        op.wdata = wdat;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_q <= 1'b0;
            dat_q <= '0;
        end else begin
            ack_q <= req;
            if (op.rd) dat_q <= rd_word;
        end
    end

    assign ack_o = ack_q;
    assign dat_o = ack_q ? dat_q : '0;

endmodule

// File: rtl/gpio_ctrl_reg.sv
module gpio_ctrl_reg
    import gpio_bank_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  bus_op_t op,
    input  logic    hw_clr,
    output ctrl_t   ctrl
);

    ctrl_t         ctrl_q;
    ctrl_t         ctrl_d;
    logic [DW-1:0] merged;
    logic          unused_top;

    assign merged     = byte_merge(ctrl_to_word(ctrl_q), op.wdata, op.sel);
    assign unused_top = ^merged[DW-1:CTRL_W];

    always_comb begin
        ctrl_d = ctrl_q;
        if (op.wr && op.slot == SLOT_CTRL) ctrl_d = ctrl_t'(merged[CTRL_W-1:0]);
        // hardware clear overrides the software write
        if (hw_clr) ctrl_d.ien = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= '0;
        else     ctrl_q <= ctrl_d;
    end

    assign ctrl = ctrl_q;

endmodule

// File: rtl/gpio_data_regs.sv
module gpio_data_regs
    import gpio_bank_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  bus_op_t         op,
    input  logic [NPIN-1:0] pad_in,
    output logic [NPIN-1:0] in_q,
    output logic [NPIN-1:0] out_q,
    output logic [NPIN-1:0] oe_q
);

    logic wr_out;
    logic wr_oe;

    assign wr_out = op.wr && op.slot == SLOT_OUT;
    assign wr_oe  = op.wr && op.slot == SLOT_OE;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_q  <= '0;
            out_q <= '0;
            oe_q  <= '0;
        end else begin
            in_q <= pad_in;
            if (wr_out) out_q <= byte_merge(out_q, op.wdata, op.sel);
            if (wr_oe)  oe_q  <= byte_merge(oe_q,  op.wdata, op.sel);
        end
    end

endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux
    import gpio_bank_pkg::*;
(
    input  logic             ovr_en,
    input  logic [PIN_W-1:0] ovr_pin,
    input  logic             ovr_out,
    input  logic             ovr_oe,
    input  logic [NPIN-1:0]  reg_out,
    input  logic [NPIN-1:0]  reg_oe,
    output logic [NPIN-1:0]  pad_out,
    output logic [NPIN-1:0]  pad_oe
);

    for (genvar i = 0; i < NPIN; i++) begin : g_pad
        logic take;
        assign take       = ovr_en && (ovr_pin == PIN_W'(i));
        assign pad_out[i] = take ? ovr_out : reg_out[i];
        assign pad_oe[i]  = take ? ovr_oe  : reg_oe[i];
    end

endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
    import gpio_bank_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wb_cyc_i,
    input  logic             wb_stb_i,
    input  logic             wb_we_i,
    input  logic [ADR_W-1:0] wb_adr_i,
    input  logic [NBYTE-1:0] wb_sel_i,
    input  logic [DW-1:0]    wb_dat_i,
    output logic [DW-1:0]    wb_dat_o,
    output logic             wb_ack_o,
    input  logic             in_done_i,
    input  logic             str_out_i,
    input  logic             str_oe_i,
    output logic             cfg_in_en_o,
    output logic [PIN_W-1:0] cfg_in_pin_o,
    output logic             cfg_out_en_o,
    output logic [PIN_W-1:0] cfg_out_pin_o,
    output logic             cfg_loop_o,
    output logic [LEN_W-1:0] cfg_len_o,
    output logic             cfg_lim_o,
    input  logic [NPIN-1:0]  pad_in_i,
    output logic [NPIN-1:0]  pad_out_o,
    output logic [NPIN-1:0]  pad_oe_o
);

    bus_op_t         op;
    ctrl_t           ctrl;
    logic [NPIN-1:0] in_q;
    logic [NPIN-1:0] out_q;
    logic [NPIN-1:0] oe_q;
    logic [DW-1:0]   rd_word;

    always_comb begin
        unique case (op.slot)
            SLOT_CTRL: rd_word = ctrl_to_word(ctrl);
            SLOT_IN:   rd_word = in_q;
            SLOT_OUT:  rd_word = out_q;
            default:   rd_word = oe_q;
        endcase
    end

    gpio_bus_port u_bus (
        .clk     (clk),
        .rst     (rst),
        .cyc     (wb_cyc_i),
        .stb     (wb_stb_i),
        .we      (wb_we_i),
        .adr     (wb_adr_i),
        .sel     (wb_sel_i),
        .wdat    (wb_dat_i),
        .rd_word (rd_word),
        .op      (op),
        .dat_o   (wb_dat_o),
        .ack_o   (wb_ack_o)
    );

    gpio_ctrl_reg u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .op     (op),
        .hw_clr (in_done_i),
        .ctrl   (ctrl)
    );

    gpio_data_regs u_data (
        .clk    (clk),
        .rst    (rst),
        .op     (op),
        .pad_in (pad_in_i),
        .in_q   (in_q),
        .out_q  (out_q),
        .oe_q   (oe_q)
    );

    gpio_pad_mux u_mux (
        .ovr_en  (ctrl.oen),
        .ovr_pin (ctrl.opin),
        .ovr_out (str_out_i),
        .ovr_oe  (str_oe_i),
        .reg_out (out_q),
        .reg_oe  (oe_q),
        .pad_out (pad_out_o),
        .pad_oe  (pad_oe_o)
    );

    assign cfg_in_en_o   = ctrl.ien;
    assign cfg_in_pin_o  = ctrl.ipin;
    assign cfg_out_en_o  = ctrl.oen;
    assign cfg_out_pin_o = ctrl.opin;
    assign cfg_loop_o    = ctrl.loop;
    assign cfg_len_o     = ctrl.len;
    assign cfg_lim_o     = ctrl.lim;

endmodule

// File: rtl/gpio_regbank_chk.sv
module gpio_regbank_chk
    import gpio_bank_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             wb_cyc_i,
    input logic             wb_stb_i,
    input logic             wb_we_i,
    input logic [ADR_W-1:0] wb_adr_i,
    input logic [DW-1:0]    wb_dat_o,
    input logic             wb_ack_o,
    input logic             in_done_i,
    input logic             str_out_i,
    input logic             str_oe_i,
    input logic             cfg_in_en_o,
    input logic             cfg_out_en_o,
    input logic [PIN_W-1:0] cfg_out_pin_o,
    input logic [NPIN-1:0]  pad_out_o,
    input logic [NPIN-1:0]  pad_oe_o
);

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        wb_ack_o |=> !wb_ack_o); // R2

    AST_ACK_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        (wb_cyc_i && wb_stb_i && !wb_ack_o) |=> wb_ack_o); // R2

    AST_ACK_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(wb_ack_o) |-> $past(wb_cyc_i && wb_stb_i)); // R2

    AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (rst)
        !wb_ack_o |-> (wb_dat_o == '0)); // R2

    AST_CTRL_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (wb_ack_o && $past(!wb_we_i && wb_adr_i[3:2] == 2'd0)) |-> (wb_dat_o[DW-1:CTRL_W] == '0)); // R5

    AST_HW_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        in_done_i |=> !cfg_in_en_o); // R6

    AST_STREAM_OWNS_PIN: assert property (@(posedge clk) disable iff (rst)
        cfg_out_en_o |-> (pad_out_o[cfg_out_pin_o] == str_out_i && pad_oe_o[cfg_out_pin_o] == str_oe_i)); // R9

endmodule

bind gpio_regbank gpio_regbank_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .wb_cyc_i      (wb_cyc_i),
    .wb_stb_i      (wb_stb_i),
    .wb_we_i       (wb_we_i),
    .wb_adr_i      (wb_adr_i),
    .wb_dat_o      (wb_dat_o),
    .wb_ack_o      (wb_ack_o),
    .in_done_i     (in_done_i),
    .str_out_i     (str_out_i),
    .str_oe_i      (str_oe_i),
    .cfg_in_en_o   (cfg_in_en_o),
    .cfg_out_en_o  (cfg_out_en_o),
    .cfg_out_pin_o (cfg_out_pin_o),
    .pad_out_o     (pad_out_o),
    .pad_oe_o      (pad_oe_o)
);

// File: tb/gpio_regbank_test.sv
`timescale 1ns/1ps
module gpio_regbank_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cyc = 1'b0, stb = 1'b0, we = 1'b0;
    logic [3:0]  adr = '0;
    logic [3:0]  sel = '0;
    logic [31:0] wdat = '0;
    logic [31:0] dat_o;
    logic        ack;
    logic        in_done = 1'b0, s_out = 1'b0, s_oe = 1'b0;
    logic        in_en, out_en, loop_en, lim_en;
    logic [4:0]  in_pin, out_pin;
    logic [9:0]  len;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out, pad_oe;

    always #2 clk = ~clk;

    gpio_regbank uut (
        .clk(clk), .rst(rst),
        .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we), .wb_adr_i(adr),
        .wb_sel_i(sel), .wb_dat_i(wdat), .wb_dat_o(dat_o), .wb_ack_o(ack),
        .in_done_i(in_done), .str_out_i(s_out), .str_oe_i(s_oe),
        .cfg_in_en_o(in_en), .cfg_in_pin_o(in_pin), .cfg_out_en_o(out_en),
        .cfg_out_pin_o(out_pin), .cfg_loop_o(loop_en), .cfg_len_o(len),
        .cfg_lim_o(lim_en), .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe)
    );

    // behavioural reference state
    logic [23:0] m_ctrl;
    logic [31:0] m_in, m_out, m_oe, m_dat;
    logic        m_ack;
    int          vectors = 0;
    int          miscompares = 0;
    string       phase = "R1";

    function automatic logic [31:0] merge(logic [31:0] cur, logic [31:0] nw, logic [3:0] s);
        logic [31:0] r = cur;
        for (int b = 0; b < 4; b++) if (s[b]) r[8*b +: 8] = nw[8*b +: 8];
        return r;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_ctrl = '0; m_in = '0; m_out = '0; m_oe = '0; m_dat = '0; m_ack = 1'b0;
        end else begin
            logic req;
            logic [31:0] rv;
            logic [23:0] nc;
            req = cyc && stb && !m_ack;
            case (adr[3:2])
                2'd0: rv = {8'h00, m_ctrl};
                2'd1: rv = m_in;
                2'd2: rv = m_out;
                default: rv = m_oe;
            endcase
            nc = m_ctrl;
            if (req && !we) m_dat = rv;
            if (req && we) begin
                case (adr[3:2])
                    2'd0: nc = merge({8'h00, m_ctrl}, wdat, sel) & 32'h00FF_FFFF;
                    2'd2: m_out = merge(m_out, wdat, sel);
                    2'd3: m_oe = merge(m_oe, wdat, sel);
                    default: ;
                endcase
            end
            if (in_done) nc[0] = 1'b0;
            m_ctrl = nc;
            m_in = pad_in;
            m_ack = req;
        end
    end

    task automatic cmp(string what, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual %h expected %h at %0t", phase, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        logic [31:0] eo, ee;
        eo = m_out; ee = m_oe;
        if (m_ctrl[6]) begin
            eo[m_ctrl[11:7]] = s_out;
            ee[m_ctrl[11:7]] = s_oe;
        end
        cmp("ack", {31'd0, ack}, {31'd0, m_ack});
        cmp("dat", dat_o, m_ack ? m_dat : 32'd0);
        cmp("cfg", {8'h00, lim_en, len, loop_en, out_pin, out_en, in_pin, in_en}, {8'h00, m_ctrl});
        cmp("pad_out", pad_out, eo);
        cmp("pad_oe", pad_oe, ee);
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic access(logic w, logic [3:0] a, logic [31:0] d, logic [3:0] s);
        cyc = 1'b1; stb = 1'b1; we = w; adr = a; wdat = d; sel = s;
        step(2);
        cyc = 1'b0; stb = 1'b0; we = 1'b0;
        step(1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        step(3);
        rst = 1'b0;
        step(2);

        phase = "R3";
        access(1, 4'h8, 32'hA5A5_0F0F, 4'hF);
        access(1, 4'hC, 32'hFFFF_0000, 4'hF);
        access(0, 4'h8, 0, 4'hF);
        access(0, 4'hC, 0, 4'hF);
        access(0, 4'h0, 0, 4'hF);

        phase = "R4";
        access(1, 4'h8, 32'h1122_3344, 4'b0101);
        access(1, 4'hC, 32'h00AB_CDEF, 4'b1000);
        access(1, 4'hC, 32'h5500_0000, 4'b1000);
        access(0, 4'h8, 0, 4'h0);

        phase = "R5";
        access(1, 4'h0, 32'hFFFF_FFFF, 4'hF);
        access(0, 4'h0, 0, 4'hF);
        access(1, 4'h0, 32'h0000_0000, 4'hF);
        access(1, 4'h0, {8'h00, 1'b1, 10'd1023, 1'b0, 5'd19, 1'b0, 5'd9, 1'b1}, 4'hF);
        access(0, 4'h0, 0, 4'hF);

        phase = "R6";
        in_done = 1'b1; step(1); in_done = 1'b0; step(1);
        cyc = 1'b1; stb = 1'b1; we = 1'b1; adr = 4'h0; sel = 4'b0001; wdat = 32'h0000_0001;
        in_done = 1'b1; step(1); in_done = 1'b0;
        step(1); cyc = 1'b0; stb = 1'b0; step(1);
        access(1, 4'h0, 32'h0000_0001, 4'b0001);
        access(0, 4'h0, 0, 4'hF);

        phase = "R7";
        pad_in = 32'hCAFE_F00D; step(2);
        access(0, 4'h4, 0, 4'hF);
        access(1, 4'h4, 32'hDEAD_BEEF, 4'hF);
        pad_in = 32'h1357_9BDF; step(1);
        access(0, 4'h4, 0, 4'hF);
        cyc = 1'b1; stb = 1'b1; we = 1'b0; adr = 4'h4;
        pad_in = 32'h0F0F_F0F0; step(1);
        pad_in = 32'hFFFF_0001; step(1);
        cyc = 1'b0; stb = 1'b0; step(1);

        phase = "R2";
        cyc = 1'b1; stb = 1'b1; we = 1'b0; adr = 4'h8; step(6);
        stb = 1'b0; step(3);
        cyc = 1'b0; stb = 1'b1; step(3);
        stb = 1'b0; step(1);

        phase = "R8";
        access(1, 4'h8, 32'h8000_0001, 4'hF);
        access(1, 4'hC, 32'h0F0F_0F0F, 4'hF);
        access(1, 4'h8, 32'h7FFF_FFFE, 4'b1100);

        phase = "R9";
        access(1, 4'h0, {8'h00, 12'd0, 5'd7, 1'b1, 6'd0}, 4'hF);
        s_out = 1'b1; s_oe = 1'b0; step(1);
        s_out = 1'b0; s_oe = 1'b1; step(1);
        access(1, 4'h0, {8'h00, 12'd0, 5'd31, 1'b1, 6'd0}, 4'hF);
        s_out = 1'b1; s_oe = 1'b1; step(2);
        access(1, 4'h0, {8'h00, 12'd0, 5'd0, 1'b1, 6'd0}, 4'hF);
        s_out = 1'b0; s_oe = 1'b0; step(2);
        access(1, 4'h0, 32'h0, 4'hF);
        s_out = 1'b1; step(2);

        phase = "R1";
        rst = 1'b1; step(2); rst = 1'b0; step(2);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule